// File: doc/BRIEF.md
# Lockable Cache Way Replacement Selector

This block picks the way to be replaced when a 4-way set-associative cache misses. For every modelled set it keeps a true least-recently-used ordering of the four ways. A hit moves the hit way to most recently used. A fill moves the chosen victim to most recently used. A 32-bit lock-control register can steer some misses away from the plain LRU choice. That register has five live fields and is accessed through a simple write/read register port.

Lock mode is active when the register's lock-enable field is set, or when the processor's DSP status input is high. In lock mode, a miss caused by a prefetch can be forced into way 3 or way 2. A miss that is not a prefetch avoids the locked ways. The victim index is registered and is announced by a one-cycle valid pulse on the clock after the miss strobe. Tag storage, data storage and refill are handled elsewhere.

Top module: `lock_way_picker`

## Requirements
- R1: After reset the control register reads 0. Every set's LRU order is way 0 oldest, then way 1, then way 2, with way 3 newest.
- R2: A write stores bit 16 (lock enable), bit 9 (way-3 load), bit 8 (way-3 lock), bit 1 (way-2 load) and bit 0 (way-2 lock). All other bits read back as 0 whatever was written.
- R3: Lock mode is active when lock enable is 1, or when lock enable is 0 and dsp_mode is 1. Otherwise lock mode is inactive.
- R4: A prefetch miss in lock mode with way-3 load and way-3 lock both 1 selects way 3.
- R5: A prefetch miss in lock mode with way-2 load and way-2 lock both 1, and the way-3 pair not both 1, selects way 2.
- R6: When both load/lock pairs are fully set, a prefetch miss in lock mode selects way 3.
- R7: Outside lock mode, and for a prefetch miss in lock mode with no fully set pair, the victim is the least recently used way of the set.
- R8: A non-prefetch miss in lock mode selects the least recently used way among those whose lock bit is 0. If no way qualifies, it selects the plain LRU way.
- R9: A hit makes the hit way most recently used in its set. Ways that were newer than it each move one step older.
- R10: A miss fills the chosen victim, which becomes most recently used in its set.
- R11: When a hit and a miss occur in the same cycle, the hit update is applied first and the fill second. The victim is chosen from the order before both updates.
- R12: victim_vld is high for exactly the one cycle after each miss strobe, with victim_way holding the choice. victim_vld is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| dsp_mode | input | 1 | Processor DSP status bit |
| miss_req | input | 1 | Miss strobe, one per miss |
| miss_pf | input | 1 | Miss was caused by a prefetch |
| miss_set | input | SET_W | Set index of the miss |
| hit_req | input | 1 | Hit strobe |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | 2 | Way that hit |
| victim_way | output | 2 | Registered victim way |
| victim_vld | output | 1 | One-cycle valid for victim_way |

## Verification
A hit and a miss fill can fall in the same cycle, in the same set or in different sets. Both then update the LRU order on one clock edge. The bench provokes this with directed cycles that carry a hit and a miss on one set. Random traffic also sets both strobes together often. The outcome is judged by later misses on that set: their victims must match a model that applies the hit before the fill.

// File: rtl/lwp_pkg.sv
package lwp_pkg;
    localparam int WAYS     = 4;
    localparam int WAY_W    = 2;
    localparam int REG_W    = 32;
    localparam int LE_BIT   = 16;
    localparam int W3LD_BIT = 9;
    localparam int W3LK_BIT = 8;
    localparam int W2LD_BIT = 1;
    localparam int W2LK_BIT = 0;
    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << LE_BIT) | (REG_W'(1) << W3LD_BIT) | (REG_W'(1) << W3LK_BIT) |
        (REG_W'(1) << W2LD_BIT) | (REG_W'(1) << W2LK_BIT);

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAY_W-1:0] age_t;
    typedef age_t [WAYS-1:0]  age_vec_t;

    typedef struct packed {
        logic lock_en;
        logic w3_load;
        logic w3_lock;
        logic w2_load;
        logic w2_lock;
    } lock_cfg_t;

    localparam age_t AGE_NEWEST = age_t'(WAYS - 1);

    // Move way w to newest; ways newer than it age by one step.
    function automatic age_vec_t age_touch(age_vec_t a, way_t w);
        age_vec_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)  r[i] = AGE_NEWEST;
            else if (a[i] > a[w]) r[i] = a[i] - age_t'(1);
            else                 r[i] = a[i];
        end
        return r;
    endfunction

    // Oldest way among those not excluded; plain oldest if all excluded.
    function automatic way_t oldest_way(age_vec_t a, logic [WAYS-1:0] excl);
        way_t best;
        age_t best_age;
        logic found;
        best = '0; best_age = '1; found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!excl[i] && (!found || a[i] < best_age)) begin
                best = way_t'(i); best_age = a[i]; found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < WAYS; i++) begin
                if (a[i] < best_age || i == 0) begin
                    best = way_t'(i); best_age = a[i];
                end
            end
        end
        return best;
    endfunction
endpackage

// File: rtl/lwp_cfg_reg.sv
module lwp_cfg_reg
    import lwp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output lock_cfg_t        cfg,
    output logic [REG_W-1:0] rdata
);
    lock_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.lock_en <= wdata[LE_BIT];
            cfg_q.w3_load <= wdata[W3LD_BIT];
            cfg_q.w3_lock <= wdata[W3LK_BIT];
            cfg_q.w2_load <= wdata[W2LD_BIT];
            cfg_q.w2_lock <= wdata[W2LK_BIT];
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[LE_BIT]   = cfg_q.lock_en;
        rdata[W3LD_BIT] = cfg_q.w3_load;
        rdata[W3LK_BIT] = cfg_q.w3_lock;
        rdata[W2LD_BIT] = cfg_q.w2_load;
        rdata[W2LK_BIT] = cfg_q.w2_lock;
    end

    assign cfg = cfg_q;

    // R2
    write_readback_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata == ($past(wdata) & LIVE_MASK));
endmodule

// File: rtl/lwp_lru_bank.sv
module lwp_lru_bank
    import lwp_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  way_t             hit_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  way_t             fill_way,
    input  logic [SET_W-1:0] rd_set,
    output age_vec_t         rd_age
);
    age_vec_t ages_q [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        age_vec_t after_hit, after_fill;
        logic [WAYS-1:0] rank_seen;

        always_comb begin
            after_hit  = (hit_en && hit_set == SET_W'(s)) ? age_touch(ages_q[s], hit_way) : ages_q[s];
            after_fill = (fill_en && fill_set == SET_W'(s)) ? age_touch(after_hit, fill_way) : after_hit;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WAYS; w++) ages_q[s][w] <= age_t'(w);
            end else begin
                ages_q[s] <= after_fill;
            end
        end

        always_comb begin
            rank_seen = '0;
            for (int w = 0; w < WAYS; w++) rank_seen[ages_q[s][w]] = 1'b1;
        end

        // R9 R10
        rank_perm_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(rank_seen) == WAYS);

        for (genvar w = 0; w < WAYS; w++) begin : g_way
            // R10
            fill_newest_chk: assert property (@(posedge clk) disable iff (rst)
                (fill_en && fill_set == SET_W'(s) && fill_way == way_t'(w)) |=>
                    ages_q[s][w] == AGE_NEWEST);
        end
    end

    assign rd_age = ages_q[rd_set];
endmodule

// File: rtl/lwp_victim_sel.sv
module lwp_victim_sel
    import lwp_pkg::*;
(
    input  lock_cfg_t cfg,
    input  logic      lock_act,
    input  logic      pf,
    input  age_vec_t  age,
    output way_t      victim
);
    logic            pin3, pin2;
    logic [WAYS-1:0] locked;

    always_comb begin
        pin3   = pf && lock_act && cfg.w3_load && cfg.w3_lock;
        pin2   = pf && lock_act && cfg.w2_load && cfg.w2_lock;
        locked = '0;
        if (!pf && lock_act) begin
            locked[3] = cfg.w3_lock;
            locked[2] = cfg.w2_lock;
        end
        if (pin3)      victim = way_t'(3);
        else if (pin2) victim = way_t'(2);
        else           victim = oldest_way(age, locked);
    end
endmodule

// File: rtl/lock_way_picker.sv
module lock_way_picker
    import lwp_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             dsp_mode,
    input  logic             miss_req,
    input  logic             miss_pf,
    input  logic [SET_W-1:0] miss_set,
    input  logic             hit_req,
    input  logic [SET_W-1:0] hit_set,
    input  logic [1:0]       hit_way,
    output logic [1:0]       victim_way,
    output logic             victim_vld
);
    lock_cfg_t cfg;
    age_vec_t  miss_age;
    way_t      pick;
    logic      lock_act;
    way_t      way_q;
    logic      vld_q;

    lwp_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    assign lock_act = cfg.lock_en | dsp_mode;

    lwp_lru_bank #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_lru (
        .clk(clk), .rst(rst),
        .hit_en(hit_req), .hit_set(hit_set), .hit_way(hit_way),
        .fill_en(miss_req), .fill_set(miss_set), .fill_way(pick),
        .rd_set(miss_set), .rd_age(miss_age)
    );

    lwp_victim_sel u_sel (
        .cfg(cfg), .lock_act(lock_act), .pf(miss_pf),
        .age(miss_age), .victim(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            way_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= miss_req;
            if (miss_req) way_q <= pick;
        end
    end

    assign victim_way = way_q;
    assign victim_vld = vld_q;

    // R12
    vld_follows_miss_chk: assert property (@(posedge clk) disable iff (rst)
        miss_req |=> victim_vld);
    // R12
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !miss_req |=> !victim_vld);
    // R4 R6
    pin_way3_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && miss_pf && (cfg_rdata[16] || dsp_mode) && cfg_rdata[9] && cfg_rdata[8])
            |=> victim_way == 2'd3);
    // R5
    pin_way2_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_req && miss_pf && (cfg_rdata[16] || dsp_mode) && cfg_rdata[1] && cfg_rdata[0]
         && !(cfg_rdata[9] && cfg_rdata[8])) |=> victim_way == 2'd2);
endmodule

// File: tb/lock_way_picker_tb.sv
module lock_way_picker_tb;
    localparam int NSETS = 4;
    localparam int SW    = 2;
    localparam logic [31:0] MASK = 32'h0001_0303;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          dsp_mode = 1'b0;
    logic          miss_req = 1'b0;
    logic          miss_pf = 1'b0;
    logic [SW-1:0] miss_set = '0;
    logic          hit_req = 1'b0;
    logic [SW-1:0] hit_set = '0;
    logic [1:0]    hit_way = '0;
    logic [1:0]    victim_way;
    logic          victim_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          m_age [NSETS][4];
    logic [31:0] m_reg;

    always #4 clk = ~clk;

    lock_way_picker #(.NUM_SETS(NSETS)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dsp_mode(dsp_mode), .miss_req(miss_req), .miss_pf(miss_pf), .miss_set(miss_set),
        .hit_req(hit_req), .hit_set(hit_set), .hit_way(hit_way),
        .victim_way(victim_way), .victim_vld(victim_vld)
    );

    function automatic void touch(int s, int w);
        int a = m_age[s][w];
        for (int i = 0; i < 4; i++)
            if (i == w) m_age[s][i] = 3;
            else if (m_age[s][i] > a) m_age[s][i] = m_age[s][i] - 1;
    endfunction

    function automatic int exp_pick(int s, bit pf, bit dsp);
        bit lk = m_reg[16] | dsp;
        bit ex [4];
        int best = -1;
        if (pf && lk && m_reg[9] && m_reg[8]) return 3;
        if (pf && lk && m_reg[1] && m_reg[0]) return 2;
        for (int i = 0; i < 4; i++) ex[i] = 1'b0;
        if (!pf && lk) begin
            ex[3] = m_reg[8];
            ex[2] = m_reg[0];
        end
        for (int i = 0; i < 4; i++)
            if (!ex[i] && (best < 0 || m_age[s][i] < m_age[s][best])) best = i;
        if (best < 0) begin
            best = 0;
            for (int i = 1; i < 4; i++) if (m_age[s][i] < m_age[s][best]) best = i;
        end
        return best;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit we, logic [31:0] wd, bit dsp, bit miss, bit pf, int ms,
                        bit hit, int hs, int hw, string tag);
        int exp_w = 0;
        cfg_we = we; cfg_wdata = wd; dsp_mode = dsp;
        miss_req = miss; miss_pf = pf; miss_set = SW'(ms);
        hit_req = hit; hit_set = SW'(hs); hit_way = 2'(hw);
        if (miss) exp_w = exp_pick(ms, pf, dsp);
        if (hit) touch(hs, hw);
        if (miss) touch(ms, exp_w);
        if (we) m_reg = wd & MASK;
        @(posedge clk);
        #2;
        cfg_we = 1'b0; miss_req = 1'b0; hit_req = 1'b0;
        check(victim_vld == miss, {tag, " R12 valid"}, int'(victim_vld), int'(miss));
        if (miss) check(victim_way == 2'(exp_w), {tag, " victim"}, int'(victim_way), exp_w);
        check(cfg_rdata == m_reg, {tag, " R2 readback"}, int'(cfg_rdata), int'(m_reg));
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_reg = '0;
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < 4; w++) m_age[s][w] = w;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1 reset state
        check(cfg_rdata == 32'h0, "R1 reset register", int'(cfg_rdata), 0);
        check(victim_vld == 1'b0, "R1 reset valid", int'(victim_vld), 0);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R1 reset LRU way0 / R7");
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R10 fill becomes newest");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle");
        // R2 reserved bits
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R2 reserved zero");
        // R6 both pairs
        step(0, 0, 0, 1, 1, 1, 0, 0, 0, "R6 both pairs way3 (R3 via lock enable)");
        // R3 dsp gating with way-2 pair
        step(1, 32'h0000_0003, 0, 0, 0, 0, 0, 0, 0, "R2 write w2 pair");
        step(0, 0, 0, 1, 1, 2, 0, 0, 0, "R3 dsp low no lock / R7");
        step(0, 0, 1, 1, 1, 2, 0, 0, 0, "R3 dsp high R5 way2");
        // R4
        step(1, 32'h0001_0300, 0, 0, 0, 0, 0, 0, 0, "R2 write w3 pair");
        step(0, 0, 0, 1, 1, 3, 0, 0, 0, "R4 way3");
        step(0, 0, 0, 1, 1, 3, 0, 0, 0, "R4 way3 repeat");
        // R8 skip locked ways
        step(1, 32'h0001_0101, 0, 0, 0, 0, 0, 0, 0, "R2 write locks");
        step(0, 0, 0, 0, 0, 0, 1, 3, 0, "R9 hit");
        step(0, 0, 0, 0, 0, 0, 1, 3, 1, "R9 hit");
        step(0, 0, 0, 1, 0, 3, 0, 0, 0, "R8 skip locked");
        step(0, 0, 0, 1, 0, 3, 0, 0, 0, "R8 skip locked again");
        step(0, 0, 0, 1, 1, 3, 0, 0, 0, "R7 pf lock no pair");
        // R11 hit and fill same cycle, same set
        step(1, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R2 clear");
        step(0, 0, 0, 1, 0, 2, 1, 2, 0, "R11 hit+fill same set");
        step(0, 0, 0, 1, 0, 2, 1, 2, 3, "R11 hit+fill same set");
        step(0, 0, 0, 1, 0, 2, 0, 0, 0, "R11 follow-up");
        step(0, 0, 0, 1, 0, 2, 0, 0, 0, "R11 follow-up");
        // random mix
        for (int k = 0; k < 4000; k++) begin
            bit we  = ($urandom % 16) == 0;
            logic [31:0] wd = $urandom;
            step(we, wd, 1'($urandom), ($urandom % 3) != 0, 1'($urandom),
                 int'($urandom % NSETS), ($urandom % 2) == 0, int'($urandom % NSETS),
                 int'($urandom % 4), "R7 R8 R9 R10 R11 random");
        end
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule